// File: doc/BRIEF.md
# Disk Bus Register and Burst Cycle Sequencer

This block drives a parallel disk-interface bus for two kinds of traffic. Single register accesses come from a host request port. Word bursts go between a local data buffer and the disk. Every bus phase lasts a number of clocks that comes from a configuration input. Software must set these inputs before it starts any bus activity, and keep them steady while the bus is busy.

A host register access is never buffered. The host raises a request with direction, address and write data, and then waits for the completion pulse. For a read, the disk data comes back with that pulse. A burst starts with a one-cycle start pulse that carries a direction and a word count. When a host request arrives during a burst, the block waits for the current word's recovery to finish. It then lends the bus to the register cycle and carries on with the remaining words afterwards. No word is lost or repeated.

Top module: `dbus_seq`

## Requirements
- R1: After reset the bus is quiet: `bus_cs`, `bus_dack`, `bus_rd`, `bus_wr`, `buf_pop`, `buf_push`, `pio_done` and `dma_busy` are 0, and `pio_ready` is 1.
- R2: An accepted host request produces a register cycle with `bus_cs` high and `bus_addr` equal to the request address throughout. It has a setup phase with no strobe lasting `cfg_pio_setup` clocks, then a strobe phase lasting `cfg_pio_active` clocks, then a recovery phase with no strobe lasting `cfg_pio_recov` clocks.
- R3: Each timing input is an 8-bit clock count. A value of 0 gives a one-clock phase, and any value from 1 to 255 gives exactly that many clocks.
- R4: For a read (`pio_we`=0) the strobe is `bus_rd`. `bus_din` is sampled on the last strobe clock. `pio_done` pulses for one clock in the first recovery clock, with the sampled word on `pio_rdata`.
- R5: For a write (`pio_we`=1) the strobe is `bus_wr`, and `bus_dout` holds `pio_wdata` throughout the strobe.
- R6: `pio_ready` is 0 from the clock after a request is accepted until the strobe ends. It is 1 otherwise, including the cycle in which `pio_done` is high.
- R7: Each burst word drives `bus_dack` high for a strobe phase of `cfg_dma_active` clocks, then a recovery phase with no strobe of `cfg_dma_recov` clocks. `dma_to_disk`=1 selects `bus_wr` and `dma_to_disk`=0 selects `bus_rd`; the direction is latched at the start pulse.
- R8: When writing to disk, `bus_dout` equals `buf_rd_data` during the strobe, and `buf_pop` pulses on the last strobe clock. When reading from disk, `buf_push` pulses on the last strobe clock, with `buf_wdata` equal to `bus_din`.
- R9: A start pulse moves exactly `dma_len` words. A start with length 0 has no effect, and neither does a start while `dma_busy` is 1.
- R10: A host request made during a burst is served after the current word's recovery. The burst then resumes with its remaining words, in order, with none lost or repeated.
- R11: When a host request and a burst start meet in the idle state, the register cycle runs first.
- R12: `bus_cs` and `bus_dack` are never high together, and `bus_rd` and `bus_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pio_setup | input | 8 | Register cycle setup length in clocks |
| cfg_pio_active | input | 8 | Register cycle strobe length in clocks |
| cfg_pio_recov | input | 8 | Register cycle recovery length in clocks |
| cfg_dma_active | input | 8 | Burst word strobe length in clocks |
| cfg_dma_recov | input | 8 | Burst word recovery length in clocks |
| pio_req | input | 1 | Host register access request, held until `pio_done` |
| pio_we | input | 1 | 1 = register write, 0 = register read |
| pio_addr | input | 3 | Register address |
| pio_wdata | input | 16 | Register write data |
| pio_ready | output | 1 | Low while an accepted access is in setup or strobe |
| pio_done | output | 1 | One-clock completion pulse |
| pio_rdata | output | 16 | Read data, valid with `pio_done` |
| dma_start | input | 1 | One-clock burst start |
| dma_to_disk | input | 1 | Burst direction, 1 = buffer to disk |
| dma_len | input | 16 | Burst length in words |
| dma_busy | output | 1 | Burst words outstanding or on the bus |
| buf_rd_data | input | 16 | Head word of the outgoing buffer |
| buf_pop | output | 1 | Consume the head word of the outgoing buffer |
| buf_push | output | 1 | Store `buf_wdata` into the incoming buffer |
| buf_wdata | output | 16 | Word read from disk |
| bus_cs | output | 1 | Register cycle select |
| bus_dack | output | 1 | Burst acknowledge |
| bus_addr | output | 3 | Register address on the bus |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_dout | output | 16 | Data driven to the disk |
| bus_din | input | 16 | Data from the disk |

## Verification
The phase lengths are measured as runs of bus activity. The configuration patterns include all zeros, a 255-clock setup, and random small values. Together these show whether 0 is clamped to 1 and whether each counter is tied to the right phase. Bursts of random length and direction use a disk and buffer model with an index-dependent word pattern. A skipped, repeated or reordered word therefore shows up as a data mismatch, which exposes a broken resume after a host request breaks into a burst. Directed cases cover a start of length zero, a start while busy, and a request and a start in the same clock. These show whether the ignore rules and the idle-state priority are met.

// File: rtl/dbus_pkg.sv
package dbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PSET = 3'd1,
        PH_PACT = 3'd2,
        PH_PREC = 3'd3,
        PH_DACT = 3'd4,
        PH_DREC = 3'd5
    } phase_e;

endpackage

// File: rtl/dbus_tsel.sv
// Picks the timing count of the phase being entered and returns it minus one,
// with a zero count clamped to a single clock.
module dbus_tsel
    import dbus_pkg::*;
#(
    parameter int TW = 8
) (
    input  phase_e          ph,
    input  logic [TW-1:0]   t_pset,
    input  logic [TW-1:0]   t_pact,
    input  logic [TW-1:0]   t_prec,
    input  logic [TW-1:0]   t_dact,
    input  logic [TW-1:0]   t_drec,
    output logic [TW-1:0]   load
);
    logic [TW-1:0] sel;

    always_comb begin
        unique case (ph)
            PH_PSET: sel = t_pset;
            PH_PACT: sel = t_pact;
            PH_PREC: sel = t_prec;
            PH_DACT: sel = t_dact;
            PH_DREC: sel = t_drec;
            default: sel = '0;
        endcase
        load = (sel == '0) ? '0 : sel - 1'b1;
    end
endmodule

// File: rtl/dbus_words.sv
// Remaining burst word count and latched burst direction.
module dbus_words #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] len,
    input  logic          dir_in,
    input  logic          dec,
    output logic [LW-1:0] rem,
    output logic          dir
);
    logic [LW-1:0] rem_d, rem_q;
    logic          dir_d, dir_q;

    always_comb begin
        rem_d = rem_q;
        dir_d = dir_q;
        if (load) begin
            rem_d = len;
            dir_d = dir_in;
        end else if (dec && rem_q != '0) begin
            rem_d = rem_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            dir_q <= 1'b0;
        end else begin
            rem_q <= rem_d;
            dir_q <= dir_d;
        end
    end

    assign rem = rem_q;
    assign dir = dir_q;
endmodule

// File: rtl/dbus_seq.sv
module dbus_seq
    import dbus_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 3,
    parameter int TW = 8,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cfg_pio_setup,
    input  logic [TW-1:0] cfg_pio_active,
    input  logic [TW-1:0] cfg_pio_recov,
    input  logic [TW-1:0] cfg_dma_active,
    input  logic [TW-1:0] cfg_dma_recov,
    input  logic          pio_req,
    input  logic          pio_we,
    input  logic [AW-1:0] pio_addr,
    input  logic [DW-1:0] pio_wdata,
    output logic          pio_ready,
    output logic          pio_done,
    output logic [DW-1:0] pio_rdata,
    input  logic          dma_start,
    input  logic          dma_to_disk,
    input  logic [LW-1:0] dma_len,
    output logic          dma_busy,
    input  logic [DW-1:0] buf_rd_data,
    output logic          buf_pop,
    output logic          buf_push,
    output logic [DW-1:0] buf_wdata,
    output logic          bus_cs,
    output logic          bus_dack,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_dout,
    input  logic [DW-1:0] bus_din
);
    typedef struct packed {
        phase_e        ph;
        logic [TW-1:0] cnt;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          done;
    } st_t;

    st_t           st_d, st_q;
    phase_e        ph_nxt;
    logic [TW-1:0] load_val;
    logic [LW-1:0] rem;
    logic          dir_q;
    logic          last, in_pio, in_dma, busy_int, start_ok, word_dec;

    assign last     = (st_q.cnt == '0);
    assign in_pio   = (st_q.ph == PH_PSET) || (st_q.ph == PH_PACT) || (st_q.ph == PH_PREC);
    assign in_dma   = (st_q.ph == PH_DACT) || (st_q.ph == PH_DREC);
    assign busy_int = (rem != '0) || in_dma;
    assign start_ok = dma_start && (dma_len != '0) && !busy_int;
    assign word_dec = (st_q.ph == PH_DACT) && last;

    dbus_words #(.LW(LW)) u_words (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_ok),
        .len    (dma_len),
        .dir_in (dma_to_disk),
        .dec    (word_dec),
        .rem    (rem),
        .dir    (dir_q)
    );

    // Phase selection; host access wins only at a word boundary.
    always_comb begin
        unique case (st_q.ph)
            PH_IDLE: ph_nxt = pio_req ? PH_PSET :
                              ((start_ok || rem != '0) ? PH_DACT : PH_IDLE);
            PH_PSET: ph_nxt = last ? PH_PACT : PH_PSET;
            PH_PACT: ph_nxt = last ? PH_PREC : PH_PACT;
            PH_PREC: ph_nxt = last ? ((rem != '0) ? PH_DACT : PH_IDLE) : PH_PREC;
            PH_DACT: ph_nxt = last ? PH_DREC : PH_DACT;
            PH_DREC: ph_nxt = !last ? PH_DREC :
                              (rem == '0) ? PH_IDLE :
                              (pio_req ? PH_PSET : PH_DACT);
            default: ph_nxt = PH_IDLE;
        endcase
    end

    dbus_tsel #(.TW(TW)) u_tsel (
        .ph     (ph_nxt),
        .t_pset (cfg_pio_setup),
        .t_pact (cfg_pio_active),
        .t_prec (cfg_pio_recov),
        .t_dact (cfg_dma_active),
        .t_drec (cfg_dma_recov),
        .load   (load_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ph   = ph_nxt;
        st_d.done = 1'b0;
        st_d.cnt  = (last || st_q.ph == PH_IDLE) ? load_val : st_q.cnt - 1'b1;
        if (ph_nxt == PH_PSET && st_q.ph != PH_PSET) begin
            st_d.we    = pio_we;
            st_d.addr  = pio_addr;
            st_d.wdata = pio_wdata;
        end
        if (st_q.ph == PH_PACT && last) begin
            st_d.done = 1'b1;
            if (!st_q.we) st_d.rdata = bus_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, we: 1'b0, addr: '0,
                      wdata: '0, rdata: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pio_ready = !((st_q.ph == PH_PSET) || (st_q.ph == PH_PACT));
    assign pio_done  = st_q.done;
    assign pio_rdata = st_q.rdata;
    assign dma_busy  = busy_int;
    assign bus_cs    = in_pio;
    assign bus_dack  = in_dma;
    assign bus_addr  = in_pio ? st_q.addr : '0;
    assign bus_rd    = ((st_q.ph == PH_PACT) && !st_q.we) || ((st_q.ph == PH_DACT) && !dir_q);
    assign bus_wr    = ((st_q.ph == PH_PACT) &&  st_q.we) || ((st_q.ph == PH_DACT) &&  dir_q);
    assign bus_dout  = ((st_q.ph == PH_PACT) && st_q.we) ? st_q.wdata :
                       ((st_q.ph == PH_DACT) && dir_q)   ? buf_rd_data : '0;
    assign buf_pop   = word_dec && dir_q;
    assign buf_push  = word_dec && !dir_q;
    assign buf_wdata = bus_din;
endmodule

// File: rtl/dbus_seq_chk.sv
module dbus_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cs,
    input logic          bus_dack,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [DW-1:0] bus_dout,
    input logic          pio_ready,
    input logic          pio_done,
    input logic          buf_pop,
    input logic          buf_push
);
    assert_owner_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_dack));

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_done_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pio_done |-> $past(bus_cs && (bus_rd || bus_wr)));

    assert_ready_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pio_done |-> pio_ready);

    assert_stall_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs) |-> !pio_ready);

    assert_buf_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_pop || buf_push) |-> (bus_dack && (bus_rd || bus_wr)));

    assert_wdata_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && $past(bus_cs && bus_wr)) |-> $stable(bus_dout));
endmodule

bind dbus_seq dbus_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_dack  (bus_dack),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_dout  (bus_dout),
    .pio_ready (pio_ready),
    .pio_done  (pio_done),
    .buf_pop   (buf_pop),
    .buf_push  (buf_push)
);

// File: tb/dbus_seq_tb.sv
module dbus_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  c_ps, c_pa, c_pr, c_da, c_dr;
    logic        pio_req, pio_we;
    logic [2:0]  pio_addr;
    logic [15:0] pio_wdata;
    logic        pio_ready, pio_done;
    logic [15:0] pio_rdata;
    logic        dma_start, dma_to_disk;
    logic [15:0] dma_len;
    logic        dma_busy;
    logic [15:0] buf_rd_data;
    logic        buf_pop, buf_push;
    logic [15:0] buf_wdata;
    logic        bus_cs, bus_dack, bus_rd, bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_dout, bus_din;

    int checks = 0, errors = 0, cyc = 0;
    int push_seen = 0, pop_seen = 0, exp_push = 0, exp_pop = 0;
    int prev_cls = 0, run_len = 0;
    bit after_stb = 0;
    logic [2:0]  exp_addr;
    logic [15:0] exp_wdata;
    string cur_tag = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] pio_word(logic [2:0] a);
        return 16'(32'h1357 * (int'(a) + 1));
    endfunction
    function automatic logic [15:0] dma_word(int i);
        return 16'(i * 32'h0101) ^ 16'hC3A5;
    endfunction
    function automatic logic [15:0] src_word(int i);
        return 16'(i * 32'h0203 + 32'h0F0F);
    endfunction
    function automatic int eff(logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    assign bus_din     = bus_cs ? pio_word(bus_addr) : dma_word(push_seen);
    assign buf_rd_data = src_word(pop_seen);

    dbus_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_pio_setup(c_ps), .cfg_pio_active(c_pa), .cfg_pio_recov(c_pr),
        .cfg_dma_active(c_da), .cfg_dma_recov(c_dr),
        .pio_req(pio_req), .pio_we(pio_we), .pio_addr(pio_addr), .pio_wdata(pio_wdata),
        .pio_ready(pio_ready), .pio_done(pio_done), .pio_rdata(pio_rdata),
        .dma_start(dma_start), .dma_to_disk(dma_to_disk), .dma_len(dma_len),
        .dma_busy(dma_busy), .buf_rd_data(buf_rd_data), .buf_pop(buf_pop),
        .buf_push(buf_push), .buf_wdata(buf_wdata), .bus_cs(bus_cs),
        .bus_dack(bus_dack), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_dout(bus_dout), .bus_din(bus_din)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog R10 act=%0d exp=%0d", cyc, WD_LIMIT - 1);
            summary();
        end
    end

    // Bus monitor: run lengths, data on strobes, buffer traffic.
    always @(negedge clk) begin
        int cls;
        if (rst_n) begin
            cls = bus_cs ? ((bus_rd || bus_wr) ? 2 : 1) :
                  bus_dack ? ((bus_rd || bus_wr) ? 3 : 4) : 0;
            if (bus_cs && bus_dack) chk(0, "R12", "cs and dack together", 1, 0);
            if (bus_rd && bus_wr)   chk(0, "R12", "rd and wr together", 1, 0);
            if (cls != prev_cls && prev_cls != 0) begin
                case (prev_cls)
                    1: chk(run_len == (after_stb ? eff(c_pr) : eff(c_ps)), cur_tag,
                           after_stb ? "pio recovery length" : "pio setup length",
                           run_len, after_stb ? eff(c_pr) : eff(c_ps));
                    2: chk(run_len == eff(c_pa), cur_tag, "pio strobe length", run_len, eff(c_pa));
                    3: chk(run_len == eff(c_da), "R7", "dma strobe length", run_len, eff(c_da));
                    default: chk(run_len == eff(c_dr), "R7", "dma recovery length", run_len, eff(c_dr));
                endcase
            end
            if (prev_cls == 2 && cls != 2) after_stb = 1;
            if (cls != 1 && cls != 2) after_stb = 0;
            run_len  = (cls == prev_cls) ? run_len + 1 : 1;
            prev_cls = cls;
            if ((cls == 1 || cls == 2) && !after_stb && pio_ready)
                chk(0, "R6", "ready high during stall", 1, 0);
            if (cls == 1 || cls == 2)
                chk(bus_addr == exp_addr, "R2", "bus address", bus_addr, exp_addr);
            if (cls == 2 && bus_wr)
                chk(bus_dout == exp_wdata, "R5", "pio write data", bus_dout, exp_wdata);
            if (cls == 3 && bus_wr)
                chk(bus_dout == src_word(pop_seen), "R8", "dma write data",
                    bus_dout, src_word(pop_seen));
            if (buf_push) begin
                chk(buf_wdata == dma_word(push_seen), "R10", "dma read word order",
                    buf_wdata, dma_word(push_seen));
                push_seen++;
            end
            if (buf_pop) pop_seen++;
        end
    end

    task automatic pio_op(input logic we, input logic [2:0] a, input logic [15:0] wd,
                          output bit busy_at_done);
        @(negedge clk);
        exp_addr = a; exp_wdata = wd;
        pio_we = we; pio_addr = a; pio_wdata = wd; pio_req = 1'b1;
        do @(negedge clk); while (!pio_done);
        busy_at_done = dma_busy;
        chk(pio_ready == 1'b1, "R6", "ready at done", pio_ready, 1);
        if (!we) chk(pio_rdata == pio_word(a), "R4", "read data", pio_rdata, pio_word(a));
        pio_req = 1'b0;
        @(negedge clk);
        chk(pio_done == 1'b0, "R6", "done one clock", pio_done, 0);
    endtask

    task automatic dma_go(input logic dir, input int len, input bit counted);
        @(negedge clk);
        dma_to_disk = dir; dma_len = 16'(len); dma_start = 1'b1;
        if (counted) begin
            if (dir) exp_pop += len; else exp_push += len;
        end
        @(negedge clk);
        dma_start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        while (dma_busy || bus_cs) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(push_seen == exp_push, tag, "words pushed", push_seen, exp_push);
        chk(pop_seen == exp_pop, tag, "words popped", pop_seen, exp_pop);
    endtask

    initial begin
        bit b;
        void'($urandom(32'd2024));
        rst_n = 1'b0; pio_req = 0; pio_we = 0; pio_addr = 0; pio_wdata = 0;
        dma_start = 0; dma_to_disk = 0; dma_len = 0;
        exp_addr = 0; exp_wdata = 0;
        c_ps = 2; c_pa = 3; c_pr = 2; c_da = 2; c_dr = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!bus_cs && !bus_dack && !bus_rd && !bus_wr, "R1", "bus quiet", bus_cs, 0);
        chk(pio_ready && !pio_done, "R1", "host port idle", pio_ready, 1);
        chk(!dma_busy && !buf_pop && !buf_push, "R1", "burst idle", dma_busy, 0);

        // R2 R4 R5 basic register cycles
        pio_op(1'b1, 3'd5, 16'hBEEF, b);
        pio_op(1'b0, 3'd2, 16'h0000, b);
        wait_idle("R2");

        // R3 zero counts clamp to one clock, then a 255-clock setup
        cur_tag = "R3";
        c_ps = 0; c_pa = 0; c_pr = 0; c_da = 0; c_dr = 0;
        pio_op(1'b0, 3'd7, 16'h0, b);
        wait_idle("R3");
        c_ps = 255; c_pa = 1; c_pr = 1;
        pio_op(1'b1, 3'd1, 16'h1234, b);
        wait_idle("R3");
        cur_tag = "R2";

        // R7 R8 bursts both ways
        c_ps = 1; c_pa = 2; c_pr = 1; c_da = 3; c_dr = 2;
        dma_go(1'b1, 4, 1); wait_idle("R8");
        dma_go(1'b0, 5, 1); wait_idle("R8");

        // R9 zero length and start while busy are ignored
        dma_go(1'b0, 0, 1);
        chk(dma_busy == 1'b0, "R9", "zero length start", dma_busy, 0);
        dma_go(1'b0, 4, 1);
        repeat (3) @(negedge clk);
        dma_go(1'b1, 9, 0);
        wait_idle("R9");

        // R10 preemption mid-burst, then resume
        dma_go(1'b0, 6, 1);
        repeat (5) @(negedge clk);
        pio_op(1'b0, 3'd3, 16'h0, b);
        chk(b == 1'b1, "R10", "burst paused not finished at done", b, 1);
        wait_idle("R10");

        // R11 simultaneous request and start in idle
        @(negedge clk);
        exp_addr = 3'd4; pio_addr = 3'd4; pio_we = 1'b0; pio_req = 1'b1;
        dma_to_disk = 1'b0; dma_len = 16'd2; dma_start = 1'b1; exp_push += 2;
        @(negedge clk);
        dma_start = 1'b0;
        chk(bus_cs && !bus_dack, "R11", "register cycle first", bus_dack, 0);
        while (!pio_done) @(negedge clk);
        chk(pio_rdata == pio_word(3'd4), "R11", "read data", pio_rdata, pio_word(3'd4));
        pio_req = 1'b0;
        wait_idle("R11");

        // Random mix
        for (int i = 0; i < 40; i++) begin
            int op;
            c_ps = 8'($urandom % 6); c_pa = 8'($urandom % 6); c_pr = 8'($urandom % 6);
            c_da = 8'($urandom % 6); c_dr = 8'($urandom % 6);
            op = int'($urandom % 3);
            if (op == 2) begin
                dma_go(1'($urandom % 2), 1 + int'($urandom % 5), 1);
                if ($urandom % 2 == 1) begin
                    repeat (int'($urandom % 9)) @(negedge clk);
                    pio_op(1'($urandom % 2), 3'($urandom), 16'($urandom), b);
                end
            end else begin
                pio_op(op == 0, 3'($urandom), 16'($urandom), b);
            end
            wait_idle("R10");
        end
        summary();
    end
endmodule